// File: doc/BRIEF.md
# PWM Timer with Emergency Stop

This block is a single-channel up-counting pulse-width timer. Its P output and its complementary N output are derived from a free-running count that wraps at a programmable period and is compared against a duty value. Software starts the timer in one of two ways. It can set the run bit, and counting then begins on the next timer tick. It can also arm the timer and let a falling edge on an external event input start the count.

Four external fault inputs can act as an emergency-stop trigger, and a select field picks one of them. With the emergency function enabled, a rising edge on the selected input has four effects. It clears the run bit, drives both outputs low, latches a sticky flag and raises the interrupt if that is enabled. The running status follows the run bit one tick later, and the count is held rather than cleared. A restart has three steps: software clears the flag, waits for the status to fall, and sets run again.

A single write port reaches the register set. Run, status, flag, count and interrupt are brought straight out to ports.

Top module: `pwm_estop_timer`

## Requirements
- R1: While the status bit (stat_o) is 1, the count advances by one on each tick and goes from 0 up to PERIOD. On the tick after PERIOD it returns to 0. With PERIOD=9, the count never exceeds 9 and it reaches both 0 and 9.
- R2: While stat_o is 1 and the flag is 0, pwm_p is 1 exactly when the count is below DUTY, and pwm_n is its inverse. Both are registered, one clock behind the count. While stat_o is 0 or the flag is 1, both are 0 from the next clock. With PERIOD=9 and DUTY=3, pwm_p is high in 6 of any 20 consecutive ticks.
- R3: Register map: address 0 is control, address 1 is PERIOD, address 2 is DUTY and address 3 is status. The control bits are: bit0 run, bit1 emergency enable, bit2 event-start mode, bit3 interrupt enable, bits5:4 emergency source select. In direct mode, stat_o rises on the first tick after run is set. In event mode, stat_o rises only on a tick that sees a falling edge of the synchronized event input while run is 1.
- R4: With emergency enable at 1, a rising edge on the selected fault input (after a two-flop synchronizer) clears run and sets the flag. Both outputs then go low.
- R5: After run is cleared, stat_o falls on the following tick. While stat_o is 0 the count holds its value.
- R6: A control write with run=1 is ignored while run is 0 and either stat_o or the flag is 1.
- R7: Writing 1 to bit0 at the status address clears the flag. Writing 0 there leaves it unchanged.
- R8: While the flag is 1, event-input edges do not start the counter.
- R9: An emergency stop does not reset the count. A restart resumes counting from the held value.
- R10: Only the selected fault input can stop the timer. Changing the select does not produce an edge when the newly selected input is already high. With emergency enable at 0, fault edges have no effect.
- R11: irq is the registered AND of the flag and the interrupt enable bit.
- R12: Synchronous active-high reset sets run, stat_o, the flag, irq, both outputs and the count to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer clock enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | CNT_W | Register write data |
| evt_in | input | 1 | Event start input (falling edge) |
| emg_in | input | N_EMG | Candidate emergency-stop inputs |
| pwm_p | output | 1 | Positive PWM output |
| pwm_n | output | 1 | Complementary PWM output |
| irq | output | 1 | Emergency-stop interrupt |
| run_o | output | 1 | Run bit |
| stat_o | output | 1 | Counter actually running |
| emg_flag_o | output | 1 | Emergency-stop status flag |
| count_o | output | CNT_W | Current count |

## Verification
Most internal faults in this block show up at the ports within a few clocks. If the status bit fails to drop after a stop, the count keeps moving on the second tick after run falls. If the flag is lost, irq falls and a later event edge or run write restarts the counter at once. A wrong compare shows up as a high-time count over a window of two periods, and a missing complement shows up on the first tick. A false edge caused by the select appears as a flag within four clocks of the control write.

// File: rtl/pet_pkg.sv
package pet_pkg;
  typedef enum logic [1:0] {
    A_CTRL   = 2'd0,
    A_PERIOD = 2'd1,
    A_DUTY   = 2'd2,
    A_STATUS = 2'd3
  } pet_addr_e;

  localparam int B_RUN      = 0;
  localparam int B_EMG_EN   = 1;
  localparam int B_EVT_MODE = 2;
  localparam int B_IRQ_EN   = 3;
  localparam int B_SEL_LO   = 4;
  localparam int B_CLR_FLAG = 0;
endpackage

// File: rtl/pet_edge.sv
module pet_edge #(
  parameter int N_IN   = 4,
  parameter int SEL_W  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic [N_IN-1:0]  emg_in,
  input  logic             evt_in,
  input  logic [SEL_W-1:0] emg_sel,
  output logic             emg_rise,
  output logic             evt_fall
);
  localparam int W = N_IN + 1;

  logic [W-1:0]    sync_q [STAGES];
  logic [W-1:0]    now_w;
  logic [N_IN-1:0] rise_v;
  logic            evt_prev_q;

  assign now_w = sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) sync_q[i] <= '0;
    end else begin
      sync_q[0] <= {evt_in, emg_in};
      for (int i = 1; i < STAGES; i++) sync_q[i] <= sync_q[i-1];
    end
  end

  // Each fault input keeps its own history, so switching the select
  // compares a line only with its own past and never with another line.
  for (genvar g = 0; g < N_IN; g++) begin : g_hist
    logic prv_q;
    always_ff @(posedge clk) begin
      if (rst)       prv_q <= 1'b0;
      else if (tick) prv_q <= now_w[g];
    end
    assign rise_v[g] = now_w[g] & ~prv_q;
  end

  always_ff @(posedge clk) begin
    if (rst)       evt_prev_q <= 1'b0;
    else if (tick) evt_prev_q <= now_w[N_IN];
  end

  assign emg_rise = tick & rise_v[emg_sel];
  assign evt_fall = tick & evt_prev_q & ~now_w[N_IN];

  p_fall_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
    evt_fall |=> !evt_prev_q);
endmodule

// File: rtl/pet_ctrl.sv
module pet_ctrl
  import pet_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             emg_rise,
  input  logic             evt_fall,
  output logic             run_q,
  output logic             stat_q,
  output logic             flag_q,
  output logic             ien_q,
  output logic [SEL_W-1:0] sel_q,
  output logic [CNT_W-1:0] period_q,
  output logic [CNT_W-1:0] duty_q,
  output logic             irq_q
);
  logic emg_en_q;
  logic evt_mode_q;
  logic start_ok;

  assign start_ok = run_q & ~flag_q & (~evt_mode_q | evt_fall);

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q      <= 1'b0;
      stat_q     <= 1'b0;
      flag_q     <= 1'b0;
      ien_q      <= 1'b0;
      emg_en_q   <= 1'b0;
      evt_mode_q <= 1'b0;
      sel_q      <= '0;
      period_q   <= '1;
      duty_q     <= '0;
      irq_q      <= 1'b0;
    end else begin
      if (reg_we) begin
        case (pet_addr_e'(reg_addr))
          A_CTRL: begin
            // A set is accepted only when the timer is not winding down
            // and no emergency stop is pending.
            run_q      <= reg_wdata[B_RUN] & (run_q | (~stat_q & ~flag_q));
            emg_en_q   <= reg_wdata[B_EMG_EN];
            evt_mode_q <= reg_wdata[B_EVT_MODE];
            ien_q      <= reg_wdata[B_IRQ_EN];
            sel_q      <= reg_wdata[B_SEL_LO +: SEL_W];
          end
          A_PERIOD: period_q <= reg_wdata;
          A_DUTY:   duty_q   <= reg_wdata;
          A_STATUS: if (reg_wdata[B_CLR_FLAG]) flag_q <= 1'b0;
          default: ;
        endcase
      end
      if (tick) begin
        if (stat_q && !run_q)      stat_q <= 1'b0;
        else if (!stat_q && start_ok) stat_q <= 1'b1;
      end
      if (emg_en_q && emg_rise) begin
        run_q  <= 1'b0;
        flag_q <= 1'b1;
      end
      irq_q <= flag_q & ien_q;
    end
  end

  p_estop_halts_r4: assert property (@(posedge clk) disable iff (rst)
    (emg_en_q && emg_rise) |=> (flag_q && !run_q));
  p_stat_lag_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && stat_q && !run_q) |=> !stat_q);
  p_run_lock_r6: assert property (@(posedge clk) disable iff (rst)
    (!run_q && (stat_q || flag_q)) |=> !run_q);
  p_no_start_pending_r8: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !stat_q) |=> !stat_q);
endmodule

// File: rtl/pet_count.sv
module pet_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             stat,
  input  logic             flag,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] duty,
  output logic [CNT_W-1:0] count_q,
  output logic             pwm_p,
  output logic             pwm_n
);
  logic force_low;
  logic below;

  assign force_low = flag | ~stat;
  assign below     = count_q < duty;

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      pwm_p   <= 1'b0;
      pwm_n   <= 1'b0;
    end else begin
      if (tick && stat) count_q <= (count_q >= period) ? '0 : count_q + 1'b1;
      pwm_p <= ~force_low & below;
      pwm_n <= ~force_low & ~below;
    end
  end

  p_force_low_r2: assert property (@(posedge clk) disable iff (rst)
    force_low |=> (!pwm_p && !pwm_n));
  p_complement_r2: assert property (@(posedge clk) disable iff (rst)
    (stat && !flag) |=> (pwm_p != pwm_n));
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (!stat || !tick) |=> $stable(count_q));
endmodule

// File: rtl/pwm_estop_timer.sv
module pwm_estop_timer #(
  parameter int CNT_W  = 16,
  parameter int N_EMG  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [CNT_W-1:0] reg_wdata,
  input  logic             evt_in,
  input  logic [N_EMG-1:0] emg_in,
  output logic             pwm_p,
  output logic             pwm_n,
  output logic             irq,
  output logic             run_o,
  output logic             stat_o,
  output logic             emg_flag_o,
  output logic [CNT_W-1:0] count_o
);
  localparam int SEL_W = (N_EMG > 1) ? $clog2(N_EMG) : 1;

  logic             emg_rise, evt_fall;
  logic             ien;
  logic [SEL_W-1:0] sel;
  logic [CNT_W-1:0] period, duty;

  pet_edge #(.N_IN(N_EMG), .SEL_W(SEL_W), .STAGES(STAGES)) u_edge (
    .clk(clk), .rst(rst), .tick(tick), .emg_in(emg_in), .evt_in(evt_in),
    .emg_sel(sel), .emg_rise(emg_rise), .evt_fall(evt_fall)
  );

  pet_ctrl #(.CNT_W(CNT_W), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .emg_rise(emg_rise), .evt_fall(evt_fall),
    .run_q(run_o), .stat_q(stat_o), .flag_q(emg_flag_o), .ien_q(ien),
    .sel_q(sel), .period_q(period), .duty_q(duty), .irq_q(irq)
  );

  pet_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .tick(tick), .stat(stat_o), .flag(emg_flag_o),
    .period(period), .duty(duty), .count_q(count_o),
    .pwm_p(pwm_p), .pwm_n(pwm_n)
  );

  p_irq_follows_r11: assert property (@(posedge clk) disable iff (rst)
    (emg_flag_o && ien) |=> irq);
endmodule

// File: tb/pwm_estop_timer_test.sv
module pwm_estop_timer_test;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          tick = 1'b1;
  logic          reg_we = 1'b0;
  logic [1:0]    reg_addr = '0;
  logic [CW-1:0] reg_wdata = '0;
  logic          evt_in = 1'b0;
  logic [3:0]    emg_in = '0;
  logic          pwm_p, pwm_n, irq, run_o, stat_o, emg_flag_o;
  logic [CW-1:0] count_o;

  int total = 0;
  int fails = 0;
  int held;

  always #5 clk = ~clk;

  pwm_estop_timer uut (
    .clk(clk), .rst(rst), .tick(tick), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .evt_in(evt_in), .emg_in(emg_in),
    .pwm_p(pwm_p), .pwm_n(pwm_n), .irq(irq), .run_o(run_o), .stat_o(stat_o),
    .emg_flag_o(emg_flag_o), .count_o(count_o)
  );

  function automatic logic [CW-1:0] cw(input logic run, input logic en,
      input logic evt, input logic ien, input logic [1:0] sel);
    return {{(CW-6){1'b0}}, sel, ien, evt, en, run};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    chk(count_o == 0, "R12 count", count_o, 0);
    chk(!pwm_p && !pwm_n, "R12 outputs", {pwm_p, pwm_n}, 0);
    chk(!run_o && !stat_o && !emg_flag_o && !irq, "R12 state",
        {run_o, stat_o, emg_flag_o, irq}, 0);
  endtask

  task automatic t_pwm;
    int highs = 0;
    int bad = 0;
    int maxc = 0;
    bit seen0 = 0;
    wr(2'd1, 16'd9);
    wr(2'd2, 16'd3);
    wr(2'd0, cw(1, 0, 0, 0, 0));
    chk(stat_o == 0, "R3 stat before tick", stat_o, 0);
    @(negedge clk);
    chk(stat_o == 1, "R3 direct start", stat_o, 1);
    wait_n(2);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (pwm_p) highs++;
      if (pwm_p == pwm_n) bad++;
      if (count_o > maxc) maxc = count_o;
      if (count_o == 0) seen0 = 1;
    end
    chk(highs == 6, "R2 high ticks", highs, 6);
    chk(bad == 0, "R2 complement", bad, 0);
    chk(maxc == 9 && seen0, "R1 wrap at period", maxc, 9);
  endtask

  task automatic t_stop_lag;
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = cw(0, 0, 0, 0, 0);
    @(negedge clk);
    reg_wdata = cw(1, 0, 0, 0, 0);
    @(negedge clk);
    reg_we = 1'b0;
    chk(run_o == 0, "R6 set ignored while stat", run_o, 0);
    wait_n(2);
    chk(stat_o == 0, "R5 stat dropped", stat_o, 1'b0);
    held = count_o;
    wait_n(5);
    chk(count_o == held, "R5 count held", count_o, held);
    wr(2'd0, cw(1, 0, 0, 0, 0));
    chk(run_o == 1, "R6 set accepted", run_o, 1);
    @(negedge clk);
    chk(stat_o == 1, "R3 restart", stat_o, 1);
  endtask

  task automatic t_estop;
    wr(2'd1, 16'd200);
    wr(2'd2, 16'd100);
    wr(2'd0, cw(1, 1, 0, 1, 1));
    wait_n(30);
    emg_in[1] = 1'b1;
    wait_n(6);
    chk(emg_flag_o && !run_o, "R4 flag set run cleared",
        {emg_flag_o, run_o}, 2);
    chk(!stat_o, "R5 stat after stop", stat_o, 0);
    chk(!pwm_p && !pwm_n, "R4 outputs low", {pwm_p, pwm_n}, 0);
    chk(irq == 1, "R11 irq raised", irq, 1);
    held = count_o;
    chk(held != 0, "R9 count not cleared", held, 1);
    wait_n(5);
    chk(count_o == held, "R5 count frozen", count_o, held);
    emg_in[1] = 1'b0;
    wr(2'd0, cw(1, 1, 1, 1, 1));
    chk(run_o == 0, "R6 set ignored while flag", run_o, 0);
    evt_in = 1'b1; wait_n(4);
    evt_in = 1'b0; wait_n(5);
    chk(stat_o == 0, "R8 event ignored", stat_o, 0);
    wr(2'd3, 16'd0);
    wait_n(2);
    chk(emg_flag_o == 1, "R7 write zero keeps flag", emg_flag_o, 1);
    wr(2'd3, 16'd1);
    wait_n(2);
    chk(emg_flag_o == 0 && irq == 0, "R7 flag cleared", {emg_flag_o, irq}, 0);
    wr(2'd0, cw(1, 1, 1, 1, 1));
    wait_n(3);
    chk(run_o == 1 && stat_o == 0, "R3 armed waiting for event",
        {run_o, stat_o}, 2);
    evt_in = 1'b1; wait_n(4);
    evt_in = 1'b0; wait_n(5);
    chk(stat_o == 1, "R3 event start", stat_o, 1);
    chk(count_o >= held && count_o < held + 8, "R9 resume from held",
        count_o, held);
    chk(pwm_p == 1 && pwm_n == 0, "R2 output after resume", {pwm_p, pwm_n}, 2);
  endtask

  task automatic t_select;
    emg_in[2] = 1'b1;
    wait_n(5);
    chk(emg_flag_o == 0 && run_o == 1, "R10 unselected ignored", emg_flag_o, 0);
    wr(2'd0, cw(1, 1, 1, 1, 2));
    wait_n(5);
    chk(emg_flag_o == 0, "R10 select change no edge", emg_flag_o, 0);
    wr(2'd0, cw(1, 0, 1, 1, 2));
    emg_in[2] = 1'b0; wait_n(4);
    emg_in[2] = 1'b1; wait_n(5);
    chk(emg_flag_o == 0 && run_o == 1, "R10 disabled ignored", emg_flag_o, 0);
    wr(2'd0, cw(1, 1, 1, 1, 2));
    emg_in[2] = 1'b0; wait_n(4);
    emg_in[2] = 1'b1; wait_n(5);
    chk(emg_flag_o == 1 && run_o == 0, "R10 new source stops", emg_flag_o, 1);
  endtask

  task automatic t_irq_mask;
    wr(2'd0, cw(0, 1, 1, 0, 2));
    wait_n(3);
    chk(irq == 0, "R11 irq masked", irq, 0);
    wr(2'd0, cw(0, 1, 1, 1, 2));
    wait_n(3);
    chk(irq == 1, "R11 irq unmasked", irq, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    t_reset;
    t_pwm;
    t_stop_lag;
    t_estop;
    t_select;
    t_irq_mask;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog R12 actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule